// File: doc/BRIEF.md
# Event Timer Global Counter and Registers

This block is the shared half of a memory-mapped event timer. It keeps a free-running up counter that every comparator channel compares against, and it hands that count and a single global run flag to the channels. Software reaches four registers through a simple 64-bit register bus: a read-only capability word, a configuration word holding the global run flag, a per-channel interrupt status word, and the counter itself.

Each comparator channel reports two things to this block: a one-cycle match pulse, and whether it is in level or edge interrupt mode. For a level-mode channel, a match while the timer runs latches a sticky status bit that software clears by writing one. For an edge-mode channel, the status bit is held at zero. While the run flag is low the counter stands still and may be loaded from the bus. While the flag is high, counter writes are dropped.

Top module: `evt_global_core`

## Requirements
- R1: After a synchronous reset, `cnt_value` is 0, `glb_enable` is 0, every status bit is 0 and `bus_rdata` is 0.
- R2: While the run flag is 1, the counter rises by exactly one every clock and wraps modulo 2^CNT_W.
- R3: While the run flag is 0, the counter holds its value. A bus write to byte offset 0x0F0 then loads the low CNT_W bits of `bus_wdata` at the next edge. The same write is ignored while the flag is 1.
- R4: Bit 0 at offset 0x010 is the run flag. It reads back as written, all other bits read 0, and `glb_enable` shows it from the edge that takes the write.
- R5: Offset 0x000 is read-only. Bits 63:32 hold the tick period in femtoseconds (default 10,000,000). Bits 4:0 hold the channel count minus one. Bit 8 is 1 only for a 64-bit counter. Bits 23:16 hold the revision (default 0x01). All other bits are 0, and writes have no effect.
- R6: `bus_rdata` carries the selected register in the cycle after `bus_rd` is sampled, and is 0 otherwise. A counter read returns the count held at that edge. With a 32-bit counter, bits 63:32 read 0. Unmapped offsets read 0.
- R7: Status bit n (offset 0x020) is set when `ch_match[n]` is 1 while `ch_level[n]` is 1 and the run flag is 1. A match with the run flag at 0 does not set it. Writing 1 to bit n clears it, writing 0 leaves it, and bits at and above the channel count read 0.
- R8: While `ch_level[n]` is 0 (edge mode), status bit n reads 0 and stays clear.
- R9: When a setting match and a write-one clear hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one counter tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| ch_match | input | N_CH | Per-channel match pulse |
| ch_level | input | N_CH | Per-channel mode, 1 = level, 0 = edge |
| cnt_value | output | CNT_W | Current counter value to the channels |
| glb_enable | output | 1 | Global run flag to the channels |

## Verification
A counter that misses a tick, or moves while halted, shows on `cnt_value` at the very next edge. The bench compares that port against its model on every clock, so the cycle of divergence is pinpointed. Status state is only visible through reads, so a lost set, a failed clear, or a set that loses to a clear appears in the read data one cycle after the next status read. The bench reads status right after each match or clear. A second instance with a 32-bit counter exposes any leak into the upper read half as soon as that counter is read.

// File: rtl/evt_pkg.sv
package evt_pkg;

  localparam logic [11:0] OFS_CAP = 12'h000;
  localparam logic [11:0] OFS_CFG = 12'h010;
  localparam logic [11:0] OFS_STS = 12'h020;
  localparam logic [11:0] OFS_CNT = 12'h0F0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CAP,
    SEL_CFG,
    SEL_STS,
    SEL_CNT
  } reg_sel_e;

endpackage

// File: rtl/evt_addr_decode.sv
module evt_addr_decode
  import evt_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    sel = SEL_NONE;
    if (addr == ADDR_W'(OFS_CAP))      sel = SEL_CAP;
    else if (addr == ADDR_W'(OFS_CFG)) sel = SEL_CFG;
    else if (addr == ADDR_W'(OFS_STS)) sel = SEL_STS;
    else if (addr == ADDR_W'(OFS_CNT)) sel = SEL_CNT;
  end

endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q
);

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (run)   cnt_q <= cnt_q + CNT_W'(1);
    else if (load)  cnt_q <= load_val;
  end

  AST_RUN_STEP: assert property (@(posedge clk) disable iff (rst)
    run |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R2

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status #(
  parameter int N_CH = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [N_CH-1:0] ch_match,
  input  logic [N_CH-1:0] ch_level,
  input  logic            clr_we,
  input  logic [N_CH-1:0] clr_mask,
  output logic [N_CH-1:0] sts_q
);

  for (genvar i = 0; i < N_CH; i++) begin : g_bit
    logic set_i;
    assign set_i = run && ch_match[i];

    always_ff @(posedge clk) begin
      if (rst)                        sts_q[i] <= 1'b0;
      else if (!ch_level[i])          sts_q[i] <= 1'b0;
      else if (set_i)                 sts_q[i] <= 1'b1;
      else if (clr_we && clr_mask[i]) sts_q[i] <= 1'b0;
    end

    AST_EDGE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !ch_level[i] |=> !sts_q[i]); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      (run && ch_match[i] && ch_level[i]) |=> sts_q[i]); // R9

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
      (clr_we && clr_mask[i] && !(run && ch_match[i])) |=> !sts_q[i]); // R7
  end

endmodule

// File: rtl/evt_global_core.sv
module evt_global_core
  import evt_pkg::*;
#(
  parameter int          N_CH    = 3,
  parameter int          CNT_W   = 64,
  parameter int          ADDR_W  = 12,
  parameter logic [31:0] TICK_FS = 32'd10_000_000,
  parameter logic [7:0]  REV_ID  = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  input  logic [N_CH-1:0]   ch_match,
  input  logic [N_CH-1:0]   ch_level,
  output logic [CNT_W-1:0]  cnt_value,
  output logic              glb_enable
);

  localparam logic       WIDE_CNT = (CNT_W == 64);
  localparam logic [4:0] CH_FIELD = 5'(N_CH - 1);
  localparam logic [63:0] CAP_WORD =
    {TICK_FS, 8'h00, REV_ID, 7'h00, WIDE_CNT, 3'h0, CH_FIELD};

  reg_sel_e        sel;
  logic            run_q;
  logic            cnt_load;
  logic [N_CH-1:0] sts_q;
  logic [63:0]     cnt_rd;
  logic [63:0]     sts_rd;
  logic            unused_wbits;

  assign unused_wbits = ^bus_wdata;

  evt_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  always_ff @(posedge clk) begin
    if (rst)                              run_q <= 1'b0;
    else if (bus_wr && sel == SEL_CFG)    run_q <= bus_wdata[0];
  end
  assign glb_enable = run_q;

  assign cnt_load = bus_wr && (sel == SEL_CNT) && !run_q;

  evt_main_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .run      (run_q),
    .load     (cnt_load),
    .load_val (bus_wdata[CNT_W-1:0]),
    .cnt_q    (cnt_value)
  );

  evt_irq_status #(.N_CH(N_CH)) u_sts (
    .clk      (clk),
    .rst      (rst),
    .run      (run_q),
    .ch_match (ch_match),
    .ch_level (ch_level),
    .clr_we   (bus_wr && sel == SEL_STS),
    .clr_mask (bus_wdata[N_CH-1:0]),
    .sts_q    (sts_q)
  );

  if (CNT_W < 64) begin : g_narrow
    assign cnt_rd = {{(64-CNT_W){1'b0}}, cnt_value};
  end else begin : g_wide
    assign cnt_rd = cnt_value;
  end

  assign sts_rd = {{(64-N_CH){1'b0}}, sts_q & ch_level};

  always_ff @(posedge clk) begin
    if (rst || !bus_rd) bus_rdata <= '0;
    else begin
      case (sel)
        SEL_CAP: bus_rdata <= CAP_WORD;
        SEL_CFG: bus_rdata <= {63'd0, run_q};
        SEL_STS: bus_rdata <= sts_rd;
        SEL_CNT: bus_rdata <= cnt_rd;
        default: bus_rdata <= '0;
      endcase
    end
  end

  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == 64'd0); // R6

  AST_CFG_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_CFG)) |=> glb_enable == $past(bus_wdata[0])); // R4

  AST_RUN_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (run_q && bus_wr && bus_addr == ADDR_W'(OFS_CNT)) |=> cnt_value == $past(cnt_value) + CNT_W'(1)); // R3

endmodule

// File: tb/sim_evt_global_core.sv
module sim_evt_global_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [2:0]  ch_match = '0, ch_level = '0;
  logic [63:0] rdata0, rdata1;
  logic [63:0] cnt0;
  logic [31:0] cnt1;
  logic        en0, en1;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_global_core u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata0), .ch_match(ch_match),
    .ch_level(ch_level), .cnt_value(cnt0), .glb_enable(en0));

  evt_global_core #(.CNT_W(32)) u1 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata1), .ch_match(ch_match),
    .ch_level(ch_level), .cnt_value(cnt1), .glb_enable(en1));

  int    n_chk = 0, n_fail = 0;
  string tag = "R1";

  logic [63:0] m_cnt = '0;
  logic        m_en = 1'b0;
  logic [2:0]  m_sts = '0;
  logic [63:0] x_rd0 = '0, x_rd1 = '0;

  function automatic logic [63:0] cap_word(bit wide);
    return {32'd10_000_000, 8'h00, 8'h01, 7'h00, wide, 3'h0, 5'd2};
  endfunction

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference model and per-clock comparison
  always @(posedge clk) begin
    logic [63:0] n_cnt;
    logic        n_en;
    logic [2:0]  n_sts;
    if (rst) begin
      m_cnt = '0; m_en = 1'b0; m_sts = '0; x_rd0 = '0; x_rd1 = '0;
    end else begin
      x_rd0 = '0; x_rd1 = '0;
      if (bus_rd) begin
        case (bus_addr)
          12'h000: begin x_rd0 = cap_word(1'b1); x_rd1 = cap_word(1'b0); end
          12'h010: begin x_rd0 = {63'd0, m_en}; x_rd1 = x_rd0; end
          12'h020: begin x_rd0 = {61'd0, m_sts & ch_level}; x_rd1 = x_rd0; end
          12'h0F0: begin x_rd0 = m_cnt; x_rd1 = {32'd0, m_cnt[31:0]}; end
          default: ;
        endcase
      end
      n_cnt = m_cnt;
      if (m_en) n_cnt = m_cnt + 64'd1;
      else if (bus_wr && bus_addr == 12'h0F0) n_cnt = bus_wdata;
      n_en = (bus_wr && bus_addr == 12'h010) ? bus_wdata[0] : m_en;
      for (int i = 0; i < 3; i++) begin
        n_sts[i] = m_sts[i];
        if (!ch_level[i]) n_sts[i] = 1'b0;
        else if (m_en && ch_match[i]) n_sts[i] = 1'b1;
        else if (bus_wr && bus_addr == 12'h020 && bus_wdata[i]) n_sts[i] = 1'b0;
      end
      m_cnt = n_cnt; m_en = n_en; m_sts = n_sts;
    end
    #1;
    chk("cnt64", cnt0, m_cnt);
    chk("cnt32", {32'd0, cnt1}, {32'd0, m_cnt[31:0]});
    chk("enable", {62'd0, en1, en0}, {62'd0, m_en, m_en});
    chk("rdata64", rdata0, x_rd0);
    chk("rdata32", rdata1, x_rd1);
  end

  task automatic do_wr(logic [11:0] a, logic [63:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic do_rd(logic [11:0] a);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic pulse(logic [2:0] m);
    @(negedge clk); ch_match = m;
    @(negedge clk); ch_match = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tag = "R1"; idle(3); rst = 1'b0; idle(2);
    do_rd(12'h020); do_rd(12'h0F0);
    tag = "R5"; do_rd(12'h000);
    do_wr(12'h000, 64'hFFFF_FFFF_FFFF_FFFF); do_rd(12'h000);
    tag = "R6"; do_rd(12'h008); do_rd(12'h0F8);
    tag = "R3"; do_wr(12'h0F0, 64'h1234_5678_FFFF_FFF0); idle(3); do_rd(12'h0F0);
    tag = "R4"; do_wr(12'h010, 64'hFFFF_FFFF_FFFF_FFFF); do_rd(12'h010);
    tag = "R2"; idle(25); do_rd(12'h0F0);
    tag = "R3"; do_wr(12'h0F0, 64'd5); do_rd(12'h0F0);
    tag = "R7"; ch_level = 3'b111; idle(1);
    pulse(3'b101); do_rd(12'h020);
    do_wr(12'h020, 64'd0); do_rd(12'h020);
    do_wr(12'h020, 64'h1); do_rd(12'h020);
    do_wr(12'h020, 64'hFFFF_FFFF_FFFF_FFF8); do_rd(12'h020);
    tag = "R9";
    @(negedge clk); ch_match = 3'b010; bus_wr = 1'b1; bus_addr = 12'h020; bus_wdata = 64'h2;
    @(negedge clk); ch_match = '0; bus_wr = 1'b0; bus_wdata = '0;
    do_rd(12'h020);
    tag = "R8"; ch_level = 3'b011; pulse(3'b100); do_rd(12'h020);
    ch_level = 3'b111; do_rd(12'h020);
    tag = "R7"; do_wr(12'h020, 64'h7); do_wr(12'h010, 64'd0);
    pulse(3'b111); do_rd(12'h020);
    tag = "R3"; idle(4); do_rd(12'h0F0);
    do_wr(12'h0F0, 64'hFFFF_FFFF_FFFF_FFFE);
    tag = "R2"; do_wr(12'h010, 64'd1); idle(4); do_rd(12'h0F0);
    tag = "R4"; do_rd(12'h010);
    tag = "R1"; @(negedge clk); rst = 1'b1; idle(2); rst = 1'b0; idle(2); do_rd(12'h020);
    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule